// File: doc/BRIEF.md
# FIFO Fill-Level Flag Encoder

This block watches the occupancy count of a first-in first-out buffer and turns it into three registered status lines: an active-low half-level line, an active-low line that drops at either extreme (completely empty or completely full), and an "near an edge" line that rises once the buffer is well away from both extremes. Read together, the three lines distinguish six fill states. The storage array and pointers live elsewhere; this block only sees the count.

The distance from the edges at which the near-edge line changes is a threshold P chosen by a 4-bit code. The code is captured only while the master reset input is high. During that window it can be taken from the low bits of the write-side data bus when the write strobe is high, or from the read-side data bus when the read strobe is high. A reset window with no strobe selects P = 256. Codes the configured depth cannot use also fall back to 256.

Top module: `fill_flag_encoder`

## Requirements
- R1: While master reset is high, and in the cycle that follows a reset cycle, the outputs are (half_n, edge_n, near) = (1, 0, 0).
- R2: A count of 0 gives (1, 0, 0).
- R3: A count from 1 to P-1 gives (1, 1, 0); a count from P to DEPTH/2 gives (1, 1, 1).
- R4: A count from DEPTH/2+1 to DEPTH-P gives (0, 1, 1); a count from DEPTH-P+1 to DEPTH-1 gives (0, 1, 0).
- R5: A count equal to DEPTH gives (0, 0, 0). Where the ranges above overlap, the first rule listed (empty, full, lower half, upper half) applies.
- R6: The threshold code maps to P as 0000:256, 0001:16, 0010:32, 0011:64, 0100:128, 0101:256, 0110:512, 0111:1024, 1000:2048.
- R7: Code 1001 gives P = 4096 only when DEPTH is at least 16384, and code 1010 gives P = 8192 only when DEPTH is 8192; in every other case these codes, and codes 1011 to 1111, give P = 256.
- R8: Strobes while master reset is low leave the threshold unchanged.
- R9: In a reset cycle, a high write strobe captures bits [3:0] of the write bus; otherwise a high read strobe captures bits [3:0] of the read bus. Bits above bit 3 have no effect, and the write strobe wins when both are high.
- R10: A reset window in which no strobe is high leaves P = 256, whatever was loaded in an earlier window.
- R11: The outputs are registered: a count change shows on the outputs after the next rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mreset | input | 1 | Master reset, active high, synchronous; opens the threshold load window |
| wr_stb | input | 1 | Write strobe; loads the code from wr_bus during reset |
| rd_stb | input | 1 | Read strobe; loads the code from rd_bus during reset |
| wr_bus | input | BUS_W | Write-side data bus |
| rd_bus | input | BUS_W | Read-side data bus |
| fill_count | input | CNT_W | Current number of stored words, 0 to DEPTH |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| edge_n | output | 1 | Low when the buffer is empty or full |
| near | output | 1 | High when at least P words and at least P free places remain |

## Verification
The bench loads every one of the sixteen codes and drives the counts at each side of each boundary (P-1, P, DEPTH/2, DEPTH/2+1, DEPTH-P, DEPTH-P+1, plus the extremes), so a wrong entry in the code map or an off-by-one comparison shows as a near line that flips one word early or late. The codes valid only for other depths must decode to 256; a design that honoured them would drop the near line across most of the range. It also checks that strobes outside reset, upper bus bits and the read bus under a simultaneous write strobe all fail to move the threshold, and that an empty reset window restores 256 rather than keeping the last code. One check samples just before the clock edge to catch flags built without a register.

// File: rtl/fill_flag_pkg.sv
package fill_flag_pkg;

    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_DEFAULT = 4'b0000;

    typedef struct packed {
        logic half_n;
        logic edge_n;
        logic near;
    } flags_t;

    localparam flags_t FLAGS_EMPTY = '{half_n: 1'b1, edge_n: 1'b0, near: 1'b0};

endpackage

// File: rtl/thresh_select.sv
module thresh_select
    import fill_flag_pkg::*;
#(
    parameter int DEPTH = 8192,
    parameter int BUS_W = 9,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [BUS_W-1:0] wr_bus,
    input  logic [BUS_W-1:0] rd_bus,
    output logic [CNT_W-1:0] thresh
);

    localparam bit HAS_P4K = (DEPTH >= 16384);
    localparam bit HAS_P8K = (DEPTH == 8192);
    localparam logic [CNT_W-1:0] P_DEFAULT = CNT_W'(256);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              loaded;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mreset) begin
            if (wr_stb) begin
                st_d.code   = wr_bus[CODE_W-1:0];
                st_d.loaded = 1'b1;
            end else if (rd_stb) begin
                st_d.code   = rd_bus[CODE_W-1:0];
                st_d.loaded = 1'b1;
            end else if (st_q.loaded) begin
                st_d.code   = st_q.code;
            end else begin
                st_d.code   = CODE_DEFAULT;
            end
        end else begin
            st_d.loaded = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // decode of the held code into the threshold count
    logic [CNT_W-1:0] p_big;

    generate
        if (HAS_P4K) begin : g_deep
            always_comb p_big = (st_q.code == 4'b1001) ? CNT_W'(4096) : P_DEFAULT;
        end else if (HAS_P8K) begin : g_8k
            always_comb p_big = (st_q.code == 4'b1010) ? CNT_W'(8192) : P_DEFAULT;
        end else begin : g_other
            always_comb p_big = P_DEFAULT;
        end
    endgenerate

    always_comb begin
        case (st_q.code)
            4'b0001: thresh = CNT_W'(16);
            4'b0010: thresh = CNT_W'(32);
            4'b0011: thresh = CNT_W'(64);
            4'b0100: thresh = CNT_W'(128);
            4'b0110: thresh = CNT_W'(512);
            4'b0111: thresh = CNT_W'(1024);
            4'b1000: thresh = CNT_W'(2048);
            4'b1001, 4'b1010: thresh = p_big;
            default: thresh = P_DEFAULT;
        endcase
    end

    // code only moves inside a reset window
    property p_code_held_r8;
        @(posedge clk) disable iff (mreset) 1'b1 |=> $stable(st_q.code);
    endproperty
    assert property (p_code_held_r8);

    // every threshold is a single power of two
    property p_thresh_pow2_r6;
        @(posedge clk) disable iff (mreset) !mreset |-> ($countones(thresh) == 1);
    endproperty
    assert property (p_thresh_pow2_r6);

endmodule

// File: rtl/level_encode.sv
module level_encode
    import fill_flag_pkg::*;
#(
    parameter int DEPTH = 8192,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] fill_count,
    input  logic [CNT_W-1:0] thresh,
    output flags_t           flags
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] upper_lim;

    always_comb begin
        upper_lim = FULL_CNT - thresh;
        if (fill_count == '0) begin
            flags = FLAGS_EMPTY;
        end else if (fill_count >= FULL_CNT) begin
            flags = '{half_n: 1'b0, edge_n: 1'b0, near: 1'b0};
        end else if (fill_count <= HALF_CNT) begin
            flags = '{half_n: 1'b1, edge_n: 1'b1, near: (fill_count >= thresh)};
        end else begin
            flags = '{half_n: 1'b0, edge_n: 1'b1, near: (fill_count <= upper_lim)};
        end
    end

endmodule

// File: rtl/fill_flag_encoder.sv
module fill_flag_encoder
    import fill_flag_pkg::*;
#(
    parameter int DEPTH = 8192,
    parameter int BUS_W = 9,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [BUS_W-1:0] wr_bus,
    input  logic [BUS_W-1:0] rd_bus,
    input  logic [CNT_W-1:0] fill_count,
    output logic             half_n,
    output logic             edge_n,
    output logic             near
);

    logic [CNT_W-1:0] thresh;
    flags_t           enc;
    flags_t           flags_d, flags_q;

    thresh_select #(.DEPTH(DEPTH), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_thresh (
        .clk    (clk),
        .mreset (mreset),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .wr_bus (wr_bus),
        .rd_bus (rd_bus),
        .thresh (thresh)
    );

    level_encode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_encode (
        .fill_count (fill_count),
        .thresh     (thresh),
        .flags      (enc)
    );

    always_comb begin
        flags_d = mreset ? FLAGS_EMPTY : enc;
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign half_n = flags_q.half_n;
    assign edge_n = flags_q.edge_n;
    assign near   = flags_q.near;

    property p_empty_code_r2;
        @(posedge clk) disable iff (mreset)
            (fill_count == '0) |=> (half_n && !edge_n && !near);
    endproperty
    assert property (p_empty_code_r2);

    property p_full_code_r5;
        @(posedge clk) disable iff (mreset)
            (fill_count == CNT_W'(DEPTH)) |=> (!half_n && !edge_n && !near);
    endproperty
    assert property (p_full_code_r5);

    property p_edge_only_at_extremes_r5;
        @(posedge clk) disable iff (mreset)
            (!edge_n && !$past(mreset)) |->
                ($past(fill_count) == '0 || $past(fill_count) == CNT_W'(DEPTH));
    endproperty
    assert property (p_edge_only_at_extremes_r5);

endmodule

// File: tb/test_fill_flag_encoder.sv
module test_fill_flag_encoder;

    localparam int DEPTH = 8192;
    localparam int BUS_W = 9;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             mreset = 1'b1;
    logic             wr_stb = 1'b0;
    logic             rd_stb = 1'b0;
    logic [BUS_W-1:0] wr_bus = '0;
    logic [BUS_W-1:0] rd_bus = '0;
    logic [CNT_W-1:0] fill_count = '0;
    logic             half_n, edge_n, near;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    fill_flag_encoder #(.DEPTH(DEPTH), .BUS_W(BUS_W)) i_fill_flag_encoder (
        .clk        (clk),
        .mreset     (mreset),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .wr_bus     (wr_bus),
        .rd_bus     (rd_bus),
        .fill_count (fill_count),
        .half_n     (half_n),
        .edge_n     (edge_n),
        .near       (near)
    );

    function automatic int model_p(input int code);
        case (code)
            1: return 16;
            2: return 32;
            3: return 64;
            4: return 128;
            6: return 512;
            7: return 1024;
            8: return 2048;
            9: return (DEPTH >= 16384) ? 4096 : 256;
            10: return (DEPTH == 8192) ? 8192 : 256;
            default: return 256;
        endcase
    endfunction

    function automatic logic [2:0] model_flags(input int cnt, input int p);
        if (cnt == 0) return 3'b100;
        if (cnt >= DEPTH) return 3'b000;
        if (cnt <= DEPTH / 2) return {2'b11, (cnt >= p)};
        return {2'b01, (cnt <= DEPTH - p)};
    endfunction

    task automatic check(input logic [2:0] exp, input string tag);
        n_tests++;
        if ({half_n, edge_n, near} !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, {half_n, edge_n, near}, exp);
        end
    endtask

    // one reset window; strobes high in its first cycle only
    task automatic reset_window(input logic we, input int wv, input logic re, input int rv);
        @(negedge clk);
        mreset = 1'b1; wr_stb = we; rd_stb = re;
        wr_bus = BUS_W'(wv); rd_bus = BUS_W'(rv);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        check(3'b100, "R1 flags during reset");
        @(negedge clk);
        mreset = 1'b0;
    endtask

    task automatic apply_count(input int cnt);
        @(negedge clk);
        fill_count = CNT_W'(cnt);
        @(negedge clk);
    endtask

    task automatic probe(input int cnt, input int p, input string tag);
        apply_count(cnt);
        check(model_flags(cnt, p), tag);
    endtask

    task automatic t_reset_state();
        fill_count = CNT_W'(DEPTH / 2);
        reset_window(1'b0, 0, 1'b0, 0);
        check(3'b100, "R1 first cycle after reset");
    endtask

    task automatic t_sweep_code(input int code);
        int p = model_p(code);
        int pts[10] = '{0, p - 1, p, DEPTH / 2, DEPTH / 2 + 1,
                        DEPTH - p, DEPTH - p + 1, DEPTH - 1, DEPTH, 1};
        reset_window(1'b1, code, 1'b0, 0);
        foreach (pts[i]) begin
            probe(pts[i], p, $sformatf("R2 R3 R4 R5 R6 R7 code %0d count %0d", code, pts[i]));
        end
    endtask

    task automatic t_read_bus_load();
        reset_window(1'b0, 0, 1'b1, 3);
        probe(63, 64, "R9 read bus load below P");
        probe(64, 64, "R9 read bus load at P");
    endtask

    task automatic t_write_priority();
        reset_window(1'b1, 1, 1'b1, 8);
        probe(15, 16, "R9 write priority below P");
        probe(16, 16, "R9 write priority at P");
    endtask

    task automatic t_upper_bits();
        reset_window(1'b1, 9'h1F2, 1'b0, 0);
        probe(31, 32, "R9 upper bits below P");
        probe(32, 32, "R9 upper bits at P");
    endtask

    task automatic t_outside_reset();
        reset_window(1'b1, 2, 1'b0, 0);
        @(negedge clk);
        wr_stb = 1'b1; rd_stb = 1'b1; wr_bus = 9'd7; rd_bus = 9'd7;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        probe(31, 32, "R8 strobes outside reset below P");
        probe(32, 32, "R8 strobes outside reset at P");
    endtask

    task automatic t_default_window();
        reset_window(1'b1, 7, 1'b0, 0);
        reset_window(1'b0, 0, 1'b0, 0);
        probe(255, 256, "R10 default below P");
        probe(256, 256, "R10 default at P");
        probe(DEPTH - 256, 256, "R10 default upper");
    endtask

    task automatic t_latency();
        reset_window(1'b0, 0, 1'b0, 0);
        apply_count(0);
        @(negedge clk);
        fill_count = CNT_W'(DEPTH);
        @(posedge clk);
        #1;
        check(3'b000, "R11 after edge");
        @(negedge clk);
        fill_count = CNT_W'(1000);
        #1;
        check(3'b000, "R11 before edge holds old value");
        @(posedge clk);
        #1;
        check(3'b111, "R11 new value after edge");
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        for (int c = 0; c < 16; c++) t_sweep_code(c);
        t_read_bus_load();
        t_write_priority();
        t_upper_bits();
        t_outside_reset();
        t_default_window();
        t_latency();
        finish_run();
    end

endmodule